// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Non-Maskable Override

The block sits between a bank of hardware interrupt sources and a 32-bit CPU. Each hardware source raises a request and supplies its own 5-bit priority level. In every clock cycle the block picks a single winner and reports three things to the CPU: the winner's level, its 7-bit interrupt number, and the address of its entry in a vector table. All three are registered. The vector table starts at a programmable base and runs downwards in 4-byte entries. The CPU's own comparison of the level against its mask lies outside this block.

A separate non-maskable request comes from an external edge detector. It beats every other request and is reported with a fixed level and a fixed number. Taking it also sets a sticky DMA-halt bit, which drives a halt output to the DMA engine. Software clears the bit at the end of its handler through a small register write port. The same port also reloads the vector base.

Top module: `intc_nmi_arb`

## Requirements
- R1: When `nmi_i` is high, the next outputs are `irq_valid_o`=1, `irq_level_o`=15 (5'b01111) and `irq_num_o`=15 (7'b0001111), whatever the maskable requests are.
- R2: Among maskable requests, source i (bit i of `req_i`, level in `lvl_i[5*i+4:5*i]`) carries number FIRST_NUM+i (default 16+i). The smallest level wins. On equal levels the smaller number wins. A source with level 31 or with its request low never wins.
- R3: Every number that the block reports with `irq_valid_o`=1 is below 80. Numbers 80 to 255 are left to software traps.
- R4: With `irq_valid_o`=1, `vec_addr_o` = base + 0x3FC - 4*`irq_num_o`, taken modulo 2^32.
- R5: The base register resets to 0x000FFC00. A write with `wr_sel_i`=1 loads all 32 bits of `wr_data_i`. The new base applies to results registered on later edges.
- R6: A cycle with `nmi_i` high sets the halt bit, and `dma_halt_o` is 1 from the next edge on.
- R7: The halt bit holds its value until a write with `wr_sel_i`=0, which loads `wr_data_i[0]` into it. A 0 clears the bit, a 1 sets it. Writes to the base leave the bit unchanged.
- R8: A clearing write in the same cycle as `nmi_i` leaves the halt bit set.
- R9: With no NMI and no eligible request, the next outputs are `irq_valid_o`=0, `irq_level_o`=31, `irq_num_o`=0 and `vec_addr_o`=0.
- R10: Every output is registered. It reflects the inputs sampled at the previous rising edge.
- R11: While `rst` is high, the outputs are invalid, the level is 31, the halt is 0 and the base is 0x000FFC00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Maskable request per source |
| lvl_i | input | NUM_SRC*5 | Level per source, 5 bits each, source 0 in the low bits |
| nmi_i | input | 1 | Non-maskable request from the external detector |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 halt bit, 1 vector base |
| wr_data_i | input | 32 | Write data |
| irq_valid_o | output | 1 | An interrupt is presented |
| irq_level_o | output | 5 | Winning level, 31 when idle |
| irq_num_o | output | 7 | Winning interrupt number |
| vec_addr_o | output | 32 | Vector-table address of the winner |
| dma_halt_o | output | 1 | Sticky DMA halt |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. This covers the arbitration outputs, the vector address and the halt bit. The bench drives a vector on a falling edge and compares on the next falling edge, against a model whose base and halt state are updated after the expected values are formed. This is how a base write shows up only on the following vector, and how a same-cycle NMI beats a clearing write.

// File: rtl/intc_pkg.sv
package intc_pkg;

    parameter int LVL_W  = 5;
    parameter int NUM_W  = 7;
    parameter int ADDR_W = 32;

    localparam logic [LVL_W-1:0]  LVL_OFF      = '1;
    localparam logic [LVL_W-1:0]  NMI_LEVEL    = LVL_W'(15);
    localparam logic [NUM_W-1:0]  NMI_NUMBER   = NUM_W'(15);
    localparam logic [ADDR_W-1:0] BASE_RESET   = 32'h000F_FC00;
    localparam logic [ADDR_W-1:0] TABLE_TOP    = 32'h0000_03FC;
    localparam int                SW_NUM_FIRST = 80;

    typedef enum logic {
        SEL_HALT = 1'b0,
        SEL_BASE = 1'b1
    } wr_sel_e;

    typedef struct packed {
        logic             vld;
        logic [LVL_W-1:0] lvl;
        logic [NUM_W-1:0] num;
    } cand_t;

    typedef struct packed {
        logic              vld;
        logic [LVL_W-1:0]  lvl;
        logic [NUM_W-1:0]  num;
        logic [ADDR_W-1:0] addr;
    } result_t;

    // keep a unless b is strictly better (lower level, then lower number)
    function automatic cand_t better(cand_t a, cand_t b);
        cand_t r;
        r = a;
        if (b.vld) begin
            if (!a.vld)
                r = b;
            else if (b.lvl < a.lvl)
                r = b;
            else if ((b.lvl == a.lvl) && (b.num < a.num))
                r = b;
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] vec_offset(logic [NUM_W-1:0] num);
        logic [ADDR_W-1:0] scaled;
        scaled = {{(ADDR_W-NUM_W-2){1'b0}}, num, 2'b00};
        return TABLE_TOP - scaled;
    endfunction

endpackage

// File: rtl/intc_prio_chain.sv
module intc_prio_chain
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int FIRST_NUM = 16
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] lvl,
    output cand_t                    best
);

    cand_t stage [NUM_SRC+1];

    assign stage[0] = '0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        cand_t here;
        always_comb begin
            here.lvl = lvl[g*LVL_W +: LVL_W];
            here.num = NUM_W'(FIRST_NUM + g);
            here.vld = req[g] && (here.lvl != LVL_OFF);
        end
        assign stage[g+1] = better(stage[g], here);
    end

    assign best = stage[NUM_SRC];

endmodule

// File: rtl/intc_ctrl_regs.sv
module intc_ctrl_regs
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi,
    input  logic              wr_en,
    input  wr_sel_e           wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base,
    output logic              halt
);

    logic              halt_d;
    logic [ADDR_W-1:0] base_d;

    always_comb begin
        halt_d = halt;
        base_d = base;
        if (wr_en && (wr_sel == SEL_HALT))
            halt_d = wr_data[0];
        if (wr_en && (wr_sel == SEL_BASE))
            base_d = wr_data;
        // an NMI in the same cycle beats a clearing write
        if (nmi)
            halt_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt <= 1'b0;
            base <= BASE_RESET;
        end else begin
            halt <= halt_d;
            base <= base_d;
        end
    end

endmodule

// File: rtl/intc_result_stage.sv
module intc_result_stage
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi,
    input  cand_t             best,
    input  logic [ADDR_W-1:0] base,
    output result_t           res
);

    cand_t   win;
    result_t res_d;

    always_comb begin
        win = best;
        if (nmi) begin
            win.vld = 1'b1;
            win.lvl = NMI_LEVEL;
            win.num = NMI_NUMBER;
        end
        res_d.vld  = win.vld;
        res_d.lvl  = win.vld ? win.lvl : LVL_OFF;
        res_d.num  = win.vld ? win.num : '0;
        res_d.addr = win.vld ? (base + vec_offset(win.num)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res.vld  <= 1'b0;
            res.lvl  <= LVL_OFF;
            res.num  <= '0;
            res.addr <= '0;
        end else begin
            res <= res_d;
        end
    end

endmodule

// File: rtl/intc_nmi_arb.sv
module intc_nmi_arb
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int FIRST_NUM = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
    input  logic                     nmi_i,
    input  logic                     wr_en_i,
    input  logic                     wr_sel_i,
    input  logic [ADDR_W-1:0]        wr_data_i,
    output logic                     irq_valid_o,
    output logic [LVL_W-1:0]         irq_level_o,
    output logic [NUM_W-1:0]         irq_num_o,
    output logic [ADDR_W-1:0]        vec_addr_o,
    output logic                     dma_halt_o
);

    localparam int LAST_NUM = FIRST_NUM + NUM_SRC - 1;

    cand_t             best;
    result_t           res;
    logic [ADDR_W-1:0] base;
    wr_sel_e           sel;

    assign sel = wr_sel_e'(wr_sel_i);

    intc_prio_chain #(
        .NUM_SRC   (NUM_SRC),
        .FIRST_NUM (FIRST_NUM)
    ) u_chain (
        .req  (req_i),
        .lvl  (lvl_i),
        .best (best)
    );

    intc_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .nmi     (nmi_i),
        .wr_en   (wr_en_i),
        .wr_sel  (sel),
        .wr_data (wr_data_i),
        .base    (base),
        .halt    (dma_halt_o)
    );

    intc_result_stage u_res (
        .clk  (clk),
        .rst  (rst),
        .nmi  (nmi_i),
        .best (best),
        .base (base),
        .res  (res)
    );

    assign irq_valid_o = res.vld;
    assign irq_level_o = res.lvl;
    assign irq_num_o   = res.num;
    assign vec_addr_o  = res.addr;

    if (LAST_NUM >= SW_NUM_FIRST) begin : g_bad_range
        $error("hardware interrupt numbers overlap the software range");
    end

endmodule

// File: rtl/intc_nmi_arb_chk.sv
module intc_nmi_arb_chk
    import intc_pkg::*;
#(
    parameter int NUM_SRC   = 16,
    parameter int FIRST_NUM = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_SRC-1:0]       req_i,
    input logic [NUM_SRC*LVL_W-1:0] lvl_i,
    input logic                     nmi_i,
    input logic                     wr_en_i,
    input logic                     wr_sel_i,
    input logic [ADDR_W-1:0]        wr_data_i,
    input logic                     irq_valid_o,
    input logic [LVL_W-1:0]         irq_level_o,
    input logic [NUM_W-1:0]         irq_num_o,
    input logic [ADDR_W-1:0]        vec_addr_o,
    input logic                     dma_halt_o
);

    logic any_elig;
    logic halt_wr;

    always_comb begin
        any_elig = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
            if (req_i[i] && (lvl_i[i*LVL_W +: LVL_W] != LVL_OFF))
                any_elig = 1'b1;
    end

    assign halt_wr = wr_en_i && (wr_sel_i == 1'b0);

    // R1
    a_r1_nmi_wins: assert property (@(posedge clk) disable iff (rst)
        nmi_i |=> (irq_valid_o && irq_level_o == NMI_LEVEL && irq_num_o == NMI_NUMBER));

    // R3
    a_r3_hw_range: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> (int'(irq_num_o) < SW_NUM_FIRST));

    // R6
    a_r6_halt_set: assert property (@(posedge clk) disable iff (rst)
        nmi_i |=> dma_halt_o);

    // R7
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (!nmi_i && !halt_wr) |=> $stable(dma_halt_o));

    // R8
    a_r8_clear_race: assert property (@(posedge clk) disable iff (rst)
        (nmi_i && halt_wr && !wr_data_i[0]) |=> dma_halt_o);

    // R9
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (!nmi_i && !any_elig) |=> (!irq_valid_o && irq_level_o == LVL_OFF && vec_addr_o == '0));

    // R2: an eligible request always yields a valid result
    a_r2_some_win: assert property (@(posedge clk) disable iff (rst)
        any_elig |=> (irq_valid_o && irq_level_o != LVL_OFF));

endmodule

bind intc_nmi_arb intc_nmi_arb_chk #(
    .NUM_SRC   (NUM_SRC),
    .FIRST_NUM (FIRST_NUM)
) u_chk (.*);

// File: tb/intc_nmi_arb_tb.sv
`timescale 1ns/1ps
module intc_nmi_arb_tb;

    localparam int NSRC  = 16;
    localparam int FIRST = 16;

    logic              clk = 0;
    logic              rst;
    logic [NSRC-1:0]   req_i;
    logic [NSRC*5-1:0] lvl_i;
    logic              nmi_i;
    logic              wr_en_i;
    logic              wr_sel_i;
    logic [31:0]       wr_data_i;
    logic              irq_valid_o;
    logic [4:0]        irq_level_o;
    logic [6:0]        irq_num_o;
    logic [31:0]       vec_addr_o;
    logic              dma_halt_o;

    int n_vec  = 0;
    int n_fail = 0;

    logic [31:0] m_base;
    logic        m_halt;
    logic        e_vld;
    logic [4:0]  e_lvl;
    logic [6:0]  e_num;
    logic [31:0] e_addr;

    always #2.5 clk = ~clk;

    intc_nmi_arb #(.NUM_SRC(NSRC), .FIRST_NUM(FIRST)) u_dut (.*);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // expected outputs from the requirements
    task automatic predict();
        logic [4:0] bl;
        logic [6:0] bn;
        logic       bv;
        bv = 0; bl = 5'd31; bn = 0;
        for (int i = 0; i < NSRC; i++) begin
            logic [4:0] l;
            l = lvl_i[i*5 +: 5];
            if (req_i[i] && l != 5'd31 && (!bv || l < bl)) begin
                bv = 1; bl = l; bn = 7'(FIRST + i);
            end
        end
        if (nmi_i) begin
            bv = 1; bl = 5'd15; bn = 7'd15;
        end
        e_vld  = bv;
        e_lvl  = bv ? bl : 5'd31;
        e_num  = bv ? bn : 7'd0;
        e_addr = bv ? (m_base + 32'h3FC - {23'd0, bn, 2'b00}) : 32'd0;
        if (wr_en_i && !wr_sel_i) m_halt = wr_data_i[0];
        if (wr_en_i && wr_sel_i)  m_base = wr_data_i;
        if (nmi_i) m_halt = 1'b1;
    endtask

    task automatic step(string tag);
        predict();
        @(negedge clk);
        chk(tag, "valid", 32'(irq_valid_o), 32'(e_vld));
        chk(tag, "level", 32'(irq_level_o), 32'(e_lvl));
        chk(tag, "number", 32'(irq_num_o), 32'(e_num));
        chk(tag, "vector", vec_addr_o, e_addr);
        chk(tag, "halt", 32'(dma_halt_o), 32'(m_halt));
    endtask

    task automatic idle_in();
        req_i = '0; lvl_i = '1; nmi_i = 0;
        wr_en_i = 0; wr_sel_i = 0; wr_data_i = '0;
    endtask

    task automatic set_src(int i, logic [4:0] l);
        req_i[i] = 1'b1;
        lvl_i[i*5 +: 5] = l;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
        idle_in();
        rst = 1;
        m_base = 32'h000F_FC00;
        m_halt = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "valid", 32'(irq_valid_o), 0);
        chk("R11", "level", 32'(irq_level_o), 31);
        chk("R11", "halt", 32'(dma_halt_o), 0);
        rst = 0;

        // R9 idle; R10 registered latency
        step("R9");
        // R2 single source, number 16+3, R4 vector
        set_src(3, 5'd7); step("R2");
        // R2 lower level wins
        set_src(9, 5'd2); step("R2");
        // R2 tie goes to lower number
        set_src(5, 5'd2); step("R2");
        // R2 level 31 disabled
        idle_in(); set_src(1, 5'd31); step("R2");
        // R2 level without request ignored
        idle_in(); lvl_i[0 +: 5] = 5'd0; step("R2");
        // R1 NMI beats level 0
        idle_in(); set_src(0, 5'd0); nmi_i = 1; step("R1");
        // R6 halt seen, R7 holds
        idle_in(); step("R7");
        // R7 base write does not touch halt
        wr_en_i = 1; wr_sel_i = 1; wr_data_i = 32'h1234_5000; step("R7");
        // R5 new base applies, number 16 -> 0x3BC
        idle_in(); set_src(0, 5'd4); step("R5");
        // R8 clear and NMI same cycle
        idle_in(); nmi_i = 1; wr_en_i = 1; wr_data_i = 0; step("R8");
        // R7 clear
        idle_in(); wr_en_i = 1; wr_data_i = 0; step("R7");
        idle_in(); step("R7");
        // R7 software set
        wr_en_i = 1; wr_data_i = 1; step("R7");
        idle_in(); wr_en_i = 1; wr_data_i = 0; step("R7");
        // R3/R4 highest source number, base restored
        wr_en_i = 1; wr_sel_i = 1; wr_data_i = 32'h000F_FC00; step("R5");
        idle_in(); set_src(NSRC-1, 5'd30); step("R3");

        for (int k = 0; k < 400; k++) begin
            idle_in();
            for (int i = 0; i < NSRC; i++) begin
                req_i[i] = ($urandom % 3) == 0;
                lvl_i[i*5 +: 5] = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 8);
            end
            nmi_i    = ($urandom % 8) == 0;
            wr_en_i  = ($urandom % 6) == 0;
            wr_sel_i = ($urandom % 4) == 0;
            wr_data_i = $urandom;
            step("R4");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule